// File: doc/BRIEF.md
# Prioritized Interrupt Vector Unit

This block gathers the seven event sources of a two-wire serial bus master into one place and turns them into a single interrupt request. The protocol engine reports each event as a one-cycle pulse. The block latches that pulse into a status flag. A mask register chooses which flags may raise the interrupt line. A vector register reports the most urgent pending and enabled source as a small code.

Software services the block through a simple register port. It reads the vector, acts on the code it gets, and reads again until the code is zero. Each vector read acknowledges the source it reported, so no separate clear write is needed on that path. Flags can also be cleared directly by writing ones to the status register. The status register also shows the live bus-busy indication.

Top module: `irq_vector_unit`

## Requirements
- R1: After reset, every status flag and every mask bit is 0, `irq_o` is 0, and `rd_data_o` is 0.
- R2: A pulse on `evt_i[k]` sets status bit k one clock later, whatever the mask holds. The sources are: k=0 arbitration lost, k=1 no-acknowledge, k=2 access ready, k=3 receive ready, k=4 transmit ready, k=5 stop seen, k=6 addressed as target.
- R3: Address 0 is the enable mask. Bit k enables source k (same k as R2). Bits 7 and up are read as 0 and ignore writes.
- R4: A read of address 2 returns, in bits 2:0, the code k+1 of the pending and enabled source with the smallest k. It returns 0 when no enabled source is pending. Bits 15:3 read 0.
- R5: A source whose mask bit is 0 never appears in the vector and never raises `irq_o`, even while its status bit is set.
- R6: `irq_o` is high exactly when some status bit and its mask bit are both 1. It follows an event pulse by one clock.
- R7: Address 1 reads the status flags in bits 6:0. Writing it clears every flag whose data bit is 1 and leaves the others unchanged.
- R8: A vector read clears the status flag of the source it reported, so successive reads step through the pending sources in priority order.
- R9: An event on a source in the same cycle as a clear of that source, whether by status write or by vector read, leaves the flag set.
- R10: Status bit 12 shows the `bus_busy_i` input as it stands at the read. Writes to bit 12 have no effect.
- R11: Read data appears on `rd_data_o` one clock after the read request and holds until the next read. Address 3 reads 0. A write to address 2 changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_i | input | 7 | One-cycle event pulses, one per source |
| bus_busy_i | input | 1 | Live bus-busy level from the protocol engine |
| req_valid_i | input | 1 | Register access request |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 2 | Register address |
| req_wdata_i | input | 16 | Write data |
| rd_data_o | output | 16 | Registered read data |
| irq_o | output | 1 | Interrupt request |

## Verification
Two functions can meet on one flag in the same cycle: a new event pulse, and a clear. The clear comes either from a ones-write to the status register or from a vector read that acknowledges that source. The bench drives the pulse and the register access on the same falling edge. It then reads back the status register, or reads the vector twice. A correct design shows the flag still set, and the same code is returned again. A second case pairs a clear of one source with an event on a neighbouring source. That shows the clear hits only the bit that was written.

// File: rtl/ivu_pkg.sv
package ivu_pkg;

  typedef enum logic [1:0] {
    IVU_MASK = 2'd0,
    IVU_STAT = 2'd1,
    IVU_VEC  = 2'd2,
    IVU_NONE = 2'd3
  } ivu_reg_e;

endpackage

// File: rtl/ivu_flags.sv
module ivu_flags #(
  parameter int unsigned NSRC = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] set_i,
  input  logic [NSRC-1:0] clr_i,
  output logic [NSRC-1:0] flags_o
);

  // One sticky flag per source; a set in the clear cycle wins.
  for (genvar g = 0; g < NSRC; g++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rst_n)          flags_o[g] <= 1'b0;
      else if (set_i[g])   flags_o[g] <= 1'b1;
      else if (clr_i[g])   flags_o[g] <= 1'b0;
    end

    p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
      set_i[g] |=> flags_o[g]);
    p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i[g] && !set_i[g]) |=> !flags_o[g]);
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_i[g] && !set_i[g]) |=> $stable(flags_o[g]));
  end

endmodule

// File: rtl/ivu_prio.sv
module ivu_prio #(
  parameter int unsigned NSRC = 7,
  parameter int unsigned CW   = $clog2(NSRC + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] pending_i,
  output logic [CW-1:0]   code_o,
  output logic [NSRC-1:0] grant_o
);

  // Code of the lowest-index set bit, plus one; zero when none is set.
  function automatic logic [CW-1:0] first_code(input logic [NSRC-1:0] p);
    logic [CW-1:0] c;
    c = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (p[i]) c = CW'(i + 1);
    end
    return c;
  endfunction

  assign code_o = first_code(pending_i);

  for (genvar g = 0; g < NSRC; g++) begin : g_grant
    assign grant_o[g] = (code_o == CW'(g + 1));
  end

  p_grant_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_o));
  p_grant_pending_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((grant_o & pending_i) == grant_o));
  p_grant_lowest_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_o != '0) |-> (((grant_o - 1'b1) & pending_i) == '0));
  p_zero_code_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (code_o == '0) |-> (pending_i == '0));

endmodule

// File: rtl/ivu_regport.sv
module ivu_regport
  import ivu_pkg::*;
#(
  parameter int unsigned NSRC     = 7,
  parameter int unsigned DW       = 16,
  parameter int unsigned AW       = 2,
  parameter int unsigned BUSY_BIT = 12,
  parameter int unsigned CW       = $clog2(NSRC + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid_i,
  input  logic            req_write_i,
  input  logic [AW-1:0]   req_addr_i,
  input  logic [DW-1:0]   req_wdata_i,
  input  logic [NSRC-1:0] flags_i,
  input  logic            bus_busy_i,
  input  logic [CW-1:0]   vec_code_i,
  input  logic [NSRC-1:0] vec_grant_i,
  output logic [NSRC-1:0] mask_o,
  output logic [NSRC-1:0] clr_o,
  output logic [DW-1:0]   rd_data_o
);

  // Decoded access strobes, brought out as named wires.
  logic wr_mask, wr_stat, rd_any, rd_vec;
  assign wr_mask = req_valid_i && req_write_i  && (req_addr_i == AW'(IVU_MASK));
  assign wr_stat = req_valid_i && req_write_i  && (req_addr_i == AW'(IVU_STAT));
  assign rd_any  = req_valid_i && !req_write_i;
  assign rd_vec  = rd_any && (req_addr_i == AW'(IVU_VEC));

  logic unused_wdata;
  assign unused_wdata = ^req_wdata_i[DW-1:NSRC];

  always_ff @(posedge clk) begin
    if (!rst_n)       mask_o <= '0;
    else if (wr_mask) mask_o <= req_wdata_i[NSRC-1:0];
  end

  // Clear requests: ones written to status, plus the source a vector read reports.
  assign clr_o = (wr_stat ? req_wdata_i[NSRC-1:0] : '0) |
                 (rd_vec  ? vec_grant_i           : '0);

  logic [DW-1:0] rd_word;
  always_comb begin
    rd_word = '0;
    unique case (req_addr_i)
      AW'(IVU_MASK): rd_word[NSRC-1:0] = mask_o;
      AW'(IVU_STAT): begin
        rd_word[NSRC-1:0] = flags_i;
        rd_word[BUSY_BIT] = bus_busy_i;
      end
      AW'(IVU_VEC):  rd_word[CW-1:0] = vec_code_i;
      default:       rd_word = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      rd_data_o <= '0;
    else if (rd_any) rd_data_o <= rd_word;
  end

  p_mask_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_mask |=> (mask_o == $past(req_wdata_i[NSRC-1:0])));
  p_mask_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_mask |=> $stable(mask_o));
  p_vec_read_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rd_vec |=> (rd_data_o == DW'($past(vec_code_i))));
  p_rdata_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_any |=> $stable(rd_data_o));

endmodule

// File: rtl/irq_vector_unit.sv
module irq_vector_unit #(
  parameter int unsigned NSRC     = 7,
  parameter int unsigned DW       = 16,
  parameter int unsigned AW       = 2,
  parameter int unsigned BUSY_BIT = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] evt_i,
  input  logic            bus_busy_i,
  input  logic            req_valid_i,
  input  logic            req_write_i,
  input  logic [AW-1:0]   req_addr_i,
  input  logic [DW-1:0]   req_wdata_i,
  output logic [DW-1:0]   rd_data_o,
  output logic            irq_o
);

  localparam int unsigned CW = $clog2(NSRC + 1);

  logic [NSRC-1:0] flags, mask, clr, pending, grant;
  logic [CW-1:0]   vec_code;

  ivu_flags #(.NSRC(NSRC)) u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_i   (evt_i),
    .clr_i   (clr),
    .flags_o (flags)
  );

  assign pending = flags & mask;
  assign irq_o   = |pending;

  ivu_prio #(.NSRC(NSRC), .CW(CW)) u_prio (
    .clk       (clk),
    .rst_n     (rst_n),
    .pending_i (pending),
    .code_o    (vec_code),
    .grant_o   (grant)
  );

  ivu_regport #(
    .NSRC(NSRC), .DW(DW), .AW(AW), .BUSY_BIT(BUSY_BIT), .CW(CW)
  ) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid_i (req_valid_i),
    .req_write_i (req_write_i),
    .req_addr_i  (req_addr_i),
    .req_wdata_i (req_wdata_i),
    .flags_i     (flags),
    .bus_busy_i  (bus_busy_i),
    .vec_code_i  (vec_code),
    .vec_grant_i (grant),
    .mask_o      (mask),
    .clr_o       (clr),
    .rd_data_o   (rd_data_o)
  );

  logic rd_vec_req;
  assign rd_vec_req = req_valid_i && !req_write_i && (req_addr_i == AW'(2));

  p_irq_vec_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == (vec_code != '0));
  p_masked_hidden_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((grant & ~mask) == '0));
  p_vec_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_vec_req && (grant != '0) && ((evt_i & grant) == '0))
      |=> ((flags & $past(grant)) == '0));
  p_evt_irq_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((evt_i & mask) != '0) |=> irq_o);

endmodule

// File: tb/irq_vector_unit_tb.sv
`timescale 1ns/100ps
module irq_vector_unit_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [6:0]  evt_i = '0;
  logic        bus_busy_i = 1'b0;
  logic        req_valid_i = 1'b0;
  logic        req_write_i = 1'b0;
  logic [1:0]  req_addr_i = '0;
  logic [15:0] req_wdata_i = '0;
  logic [15:0] rd_data_o;
  logic        irq_o;

  int checks = 0;
  int fails  = 0;
  logic [15:0] exp_q[$];
  string       tag_q[$];
  logic        rd_seen = 1'b0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  irq_vector_unit u_dut (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .bus_busy_i(bus_busy_i),
    .req_valid_i(req_valid_i), .req_write_i(req_write_i),
    .req_addr_i(req_addr_i), .req_wdata_i(req_wdata_i),
    .rd_data_o(rd_data_o), .irq_o(irq_o)
  );

  task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=0x%04h expected=0x%04h", tag, act, exp);
    end
  endtask

  // Monitor: one clock after each read request, pop and compare.
  always @(posedge clk) rd_seen <= req_valid_i && !req_write_i && rst_n;
  always @(negedge clk) begin
    if (rd_seen && exp_q.size() > 0) begin
      automatic logic [15:0] e = exp_q.pop_front();
      automatic string t = tag_q.pop_front();
      chk(rd_data_o, e, t);
    end
  end

  task automatic rd(input logic [1:0] a, input logic [15:0] e, input string t,
                    input logic [6:0] ev = '0);
    @(negedge clk);
    req_valid_i = 1'b1; req_write_i = 1'b0; req_addr_i = a; evt_i = ev;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk);
    req_valid_i = 1'b0; evt_i = '0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d, input logic [6:0] ev = '0);
    @(negedge clk);
    req_valid_i = 1'b1; req_write_i = 1'b1; req_addr_i = a; req_wdata_i = d; evt_i = ev;
    @(negedge clk);
    req_valid_i = 1'b0; req_write_i = 1'b0; evt_i = '0;
  endtask

  task automatic pulse(input logic [6:0] ev);
    @(negedge clk); evt_i = ev;
    @(negedge clk); evt_i = '0;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk({15'b0, irq_o}, 16'h0, "R1 irq after reset");
    chk(rd_data_o, 16'h0, "R1 rd_data after reset");
    rd(2'd0, 16'h0000, "R1 mask after reset");
    rd(2'd1, 16'h0000, "R1 status after reset");
    rd(2'd2, 16'h0000, "R1 vector after reset");

    bus_busy_i = 1'b1;
    rd(2'd1, 16'h1000, "R10 busy visible");
    wr(2'd1, 16'h1000);
    rd(2'd1, 16'h1000, "R10 busy write ignored");
    bus_busy_i = 1'b0;
    rd(2'd1, 16'h0000, "R10 busy drops");

    wr(2'd0, 16'hFFFF);
    rd(2'd0, 16'h007F, "R3 mask upper bits ignored");
    wr(2'd0, 16'h0015);
    rd(2'd0, 16'h0015, "R3 mask readback");
    wr(2'd0, 16'h0000);

    pulse(7'h7F);
    chk({15'b0, irq_o}, 16'h0, "R5 irq low when all masked");
    rd(2'd1, 16'h007F, "R2 all flags set while masked");
    rd(2'd2, 16'h0000, "R5 masked sources hidden from vector");
    rd(2'd1, 16'h007F, "R8 empty vector read clears nothing");
    wr(2'd1, 16'h0024);
    rd(2'd1, 16'h005B, "R7 ones clear only written bits");
    wr(2'd1, 16'h007F);
    rd(2'd1, 16'h0000, "R7 clear all");

    wr(2'd0, 16'h007F);
    pulse(7'h10);
    chk({15'b0, irq_o}, 16'h1, "R6 irq after tx-ready event");
    rd(2'd2, 16'h0005, "R4 tx-ready code 5");
    chk({15'b0, irq_o}, 16'h0, "R8 irq drops after ack");
    rd(2'd2, 16'h0000, "R8 vector empty after ack");

    pulse(7'h4A);
    rd(2'd2, 16'h0002, "R4 first code 2");
    rd(2'd2, 16'h0004, "R8 step to code 4");
    rd(2'd2, 16'h0007, "R8 step to code 7");
    rd(2'd2, 16'h0000, "R8 step to empty");
    rd(2'd1, 16'h0000, "R8 status empty after stepping");

    wr(2'd0, 16'h007E);
    pulse(7'h21);
    chk({15'b0, irq_o}, 16'h1, "R6 irq with stop enabled");
    rd(2'd2, 16'h0006, "R5 masked arb-lost skipped, code 6");
    chk({15'b0, irq_o}, 16'h0, "R5 irq low with only masked pending");
    rd(2'd1, 16'h0001, "R5 masked flag still held");
    wr(2'd1, 16'h007F);

    pulse(7'h04);
    wr(2'd1, 16'h0004, 7'h04);
    rd(2'd1, 16'h0004, "R9 event beats status clear");
    wr(2'd1, 16'h0004, 7'h08);
    rd(2'd1, 16'h0008, "R9 neighbour event, own clear");
    wr(2'd1, 16'h007F);

    wr(2'd0, 16'h007F);
    pulse(7'h08);
    rd(2'd2, 16'h0004, "R9 vector read with same event", 7'h08);
    rd(2'd2, 16'h0004, "R9 flag survives vector ack");
    rd(2'd2, 16'h0000, "R9 then cleared");

    pulse(7'h02);
    wr(2'd2, 16'hFFFF);
    rd(2'd1, 16'h0002, "R11 vector write changes nothing");
    rd(2'd0, 16'h007F, "R11 mask unchanged by vector write");
    rd(2'd3, 16'h0000, "R11 unused address reads zero");
    @(negedge clk);
    chk(rd_data_o, 16'h0000, "R11 read data holds");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule